// File: doc/BRIEF.md
# ATM Header Check Octet Inserter

This block sits in an ATM transmit path and fills in the header error control octet of each 53-octet cell. Cells arrive one octet per beat on a valid/ready stream. A start-of-cell flag marks the first octet. The fifth octet of every cell arrives as a placeholder, and its value does not matter.

While the first four header octets go through, the block runs a CRC-8 over them, most significant bit first. It then adds the coset pattern 0x55 modulo 2 and puts the result into the fifth octet in place of the placeholder. Every other octet leaves unchanged, one register stage later. The output keeps the same valid/ready handshake and carries the start-of-cell flag through alongside the data.

The octet position inside a cell restarts at each start-of-cell flag, so a truncated cell is simply cut off by the next one. Octets that cannot be placed in a cell pass through untouched. These are the octets that arrive before the first flag after reset, and the octets beyond the 53rd.

Top module: `hec_inserter`

## Requirements
- R1: The check value is the CRC-8 with generator x^8+x^2+x+1 (0x07), taken over the first four octets of a cell, most significant bit first, with the CRC register starting from zero at every start-of-cell octet. Header 00 00 00 01 therefore gives CRC 0x07.
- R2: The fifth octet of a cell (position index 4, counting the start-of-cell octet as index 0) leaves as CRC XOR 0x55, whatever value arrived in that slot.
- R3: Octets 1 to 4 and 6 to 53 of a cell leave with the same value they arrived with.
- R4: Every accepted input octet appears on the output in the next cycle (out_valid high after the accepting clock edge), in order, with out_sof equal to its in_sof. Output beats occur only for accepted inputs.
- R5: While out_valid is high and out_ready is low, out_valid, out_data and out_sof hold their values. in_ready is high whenever out_ready is high or the output stage is empty.
- R6: A start-of-cell octet always restarts the count at octet 1, even in the middle of a cell. A cell cut short in this way gets no check octet, and the new cell gets its own.
- R7: Octets accepted before the first start-of-cell octet after reset, and octets beyond the 53rd of a cell, pass through unchanged and receive no check octet.
- R8: During and right after reset, out_valid is low.
- R9: An all-zero header gives a fifth octet of exactly 0x55.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input octet valid |
| in_ready | output | 1 | Block can take an input octet |
| in_data | input | 8 | Input octet |
| in_sof | input | 1 | Input octet is the first of a cell |
| out_valid | output | 1 | Output octet valid |
| out_ready | input | 1 | Downstream takes the output octet |
| out_data | output | 8 | Output octet, with the check octet filled in |
| out_sof | output | 1 | Output octet is the first of a cell |

## Verification
Three kinds of header are sent through the block.
- An all-zero header checks that the coset is applied. With a zero CRC, any output other than 0x55 points at the XOR.
- The header 00 00 00 01 has the known CRC 0x07. It separates a correct polynomial and bit order from an incorrect one.
- Headers with many bits set, paired with non-zero placeholder values, show whether the placeholder leaks through and whether the CRC register is cleared between cells.

Further patterns cover framing:
- a cell cut off by an early start-of-cell flag;
- octets beyond the 53rd;
- octets sent before the first flag.

Each of these separates correct position counting from a counter that fails to restart or to saturate. A random out_ready throughout the run exercises the stall path.

// File: rtl/hec_pkg.sv
package hec_pkg;
    localparam int OCTET_W = 8;
    typedef logic [OCTET_W-1:0] octet_t;

    // Pipeline state of the inserter
    typedef struct packed {
        logic   vld;
        logic   sof;
        octet_t data;
        octet_t crc;
    } hec_state_t;
endpackage

// File: rtl/hec_crc8_step.sv
// One octet of CRC-8 update, MSB first, built as a chain of bit stages.
module hec_crc8_step
    import hec_pkg::*;
#(
    parameter octet_t POLY = 8'h07
) (
    input  octet_t crc_i,
    input  octet_t data_i,
    output octet_t crc_o
);
    octet_t chain [OCTET_W+1];

    assign chain[0] = crc_i;

    for (genvar b = 0; b < OCTET_W; b++) begin : g_bit
        logic fb;
        assign fb = chain[b][OCTET_W-1] ^ data_i[OCTET_W-1-b];
        assign chain[b+1] = {chain[b][OCTET_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_o = chain[OCTET_W];
endmodule

// File: rtl/hec_octet_pos.sv
// Tracks the position of the current input octet within its cell.
module hec_octet_pos #(
    parameter int CELL_OCTETS = 53,
    localparam int POS_W = $clog2(CELL_OCTETS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_i,
    input  logic             sof_i,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] OUTSIDE = POS_W'(CELL_OCTETS);

    logic [POS_W-1:0] pos_d, pos_q;

    assign pos_o = sof_i ? '0 : pos_q;

    always_comb begin
        pos_d = pos_q;
        if (beat_i) begin
            pos_d = (pos_o == OUTSIDE) ? OUTSIDE : pos_o + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= OUTSIDE;
        else        pos_q <= pos_d;
    end
endmodule

// File: rtl/hec_inserter.sv
module hec_inserter
    import hec_pkg::*;
#(
    parameter int     CELL_OCTETS = 53,
    parameter int     HDR_OCTETS  = 4,
    parameter octet_t POLY        = 8'h07,
    parameter octet_t COSET       = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_sof
);
    localparam int POS_W = $clog2(CELL_OCTETS + 1);
    localparam logic [POS_W-1:0] HEC_POS = POS_W'(HDR_OCTETS);

    hec_state_t st_d, st_q;
    logic [POS_W-1:0] pos;
    logic             accept;
    octet_t           crc_base, crc_upd;

    assign in_ready = !st_q.vld || out_ready;
    assign accept   = in_valid && in_ready;

    hec_octet_pos #(.CELL_OCTETS(CELL_OCTETS)) u_pos (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat_i (accept),
        .sof_i  (in_sof),
        .pos_o  (pos)
    );

    assign crc_base = (pos == '0) ? '0 : st_q.crc;

    hec_crc8_step #(.POLY(POLY)) u_step (
        .crc_i  (crc_base),
        .data_i (in_data),
        .crc_o  (crc_upd)
    );

    always_comb begin
        st_d = st_q;
        if (out_ready) st_d.vld = 1'b0;
        if (accept) begin
            st_d.vld  = 1'b1;
            st_d.sof  = in_sof;
            st_d.data = (pos == HEC_POS) ? (st_q.crc ^ COSET) : in_data;
            if (pos < HEC_POS) st_d.crc = crc_upd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_sof   = st_q.sof;
endmodule

// File: rtl/hec_inserter_chk.sv
module hec_inserter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_sof,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_sof
);
    p_hold_on_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof));

    p_ready_when_draining_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);

    p_one_cycle_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && (out_sof == $past(in_sof)));

    p_no_spurious_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) && out_ready |=> !out_valid);
endmodule

bind hec_inserter hec_inserter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof)
);

// File: tb/hec_inserter_tb.sv
module hec_inserter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_sof = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_sof;

    typedef struct {
        logic [7:0] d;
        logic       s;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    bit   mon_en = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    hec_inserter u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof)
    );

    // Reference: remainder of {header, 8 zero bits} divided by 0x107 (R1)
    function automatic logic [7:0] ref_crc(input logic [31:0] h);
        logic [39:0] r;
        r = {h, 8'h00};
        for (int i = 39; i >= 8; i--) begin
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
        end
        return r[7:0];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_beat(input logic [7:0] d, input logic s, input logic [7:0] e, input string tag);
        exp_t x;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = s;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        x.d = e; x.s = s; x.tag = tag;
        exp_q.push_back(x);
        @(posedge clk);
        #1;
        check(out_valid === 1'b1, "R4 latency", int'(out_valid), 1);
        in_valid = 1'b0;
    endtask

    // Sends n octets of a cell; octet index 4 is the placeholder slot
    task automatic send_cell(input logic [31:0] hdr, input logic [7:0] slot, input int n,
                             input logic [7:0] seed, input string hec_tag);
        logic [7:0] d, e;
        string t;
        for (int i = 0; i < n; i++) begin
            if (i < 4) begin
                d = hdr[31-8*i -: 8]; e = d; t = "R3 header";
            end else if (i == 4) begin
                d = slot; e = ref_crc(hdr) ^ 8'h55; t = hec_tag;
            end else begin
                d = seed + 8'(i); e = d; t = (i >= 53) ? "R7 beyond cell" : "R3 payload";
            end
            send_beat(d, i == 0, e, t);
        end
    endtask

    // Monitor with random backpressure
    initial begin
        logic       stalled = 1'b0;
        logic [7:0] hold_d = '0;
        forever begin
            @(negedge clk);
            if (mon_en) out_ready = ($urandom_range(0, 3) != 0);
            #1;
            if (stalled) begin
                check(out_valid === 1'b1 && out_data === hold_d, "R5 stall hold",
                      int'(out_data), int'(hold_d));
            end
            stalled = out_valid && !out_ready;
            hold_d  = out_data;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected beat", int'(out_data), 0);
                end else begin
                    exp_t x;
                    x = exp_q.pop_front();
                    check(out_data === x.d, x.tag, int'(out_data), int'(x.d));
                    check(out_sof === x.s, "R4 sof copy", int'(out_sof), int'(x.s));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid === 1'b0, "R8 reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid === 1'b0, "R8 after reset", int'(out_valid), 0);
        mon_en = 1'b1;

        // R7: octets before any start-of-cell pass through
        send_beat(8'hA5, 1'b0, 8'hA5, "R7 before first sof");
        send_beat(8'h3C, 1'b0, 8'h3C, "R7 before first sof");

        // R9: all-zero header, placeholder ignored
        send_cell(32'h0000_0000, 8'hFF, 53, 8'h10, "R9 zero header");
        // R1: known vector, CRC 0x07 -> 0x52
        check((ref_crc(32'h0000_0001) ^ 8'h55) == 8'h52, "R1 reference", 0, 8'h52);
        send_cell(32'h0000_0001, 8'h00, 53, 8'h6A, "R1 idle header");
        // R2: dense headers, non-zero placeholder
        send_cell(32'hFFFF_FFFF, 8'hAB, 53, 8'h20, "R2 dense header");
        send_cell(32'h1234_5678, 8'h5A, 53, 8'h30, "R2 mixed header");
        // R6: truncated cell, then a full one
        send_cell(32'hDEAD_BEEF, 8'h11, 3, 8'h40, "R6 truncated");
        send_cell(32'hCAFE_0042, 8'h99, 53, 8'h50, "R6 after truncation");
        // R7: octets beyond the 53rd
        send_cell(32'h0F0F_F0F0, 8'h77, 57, 8'h60, "R2 before overrun");
        send_cell(32'h8000_0000, 8'h00, 53, 8'h70, "R1 top bit header");

        // drain
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule